// File: doc/BRIEF.md
# Serial Audio Port FIFO Bank with Watermark Flags

This block buffers sample words for a synchronous serial audio port. It holds two transmit FIFOs and one receive FIFO, each eight words deep. The host writes samples into the transmit FIFOs, and the serial shifter drains them. The shifter fills the receive FIFO, and the host drains it. Each FIFO is first-word-fall-through: its oldest word is always visible on a head output, and a pop strobe discards that word.

Each FIFO has a programmable 4-bit watermark and a registered level flag, which an interrupt or DMA request can use. A transmit watermark is a count of free slots. Its flag is high when at least that many slots are empty, so the fill level is at or below depth minus the code. The receive flag is high when the fill level has reached its watermark.

A single configuration write loads all three watermarks. A status word reads back the watermarks and the live word counts. Invalid requests are ignored: a push into a full FIFO or a pop from an empty FIFO. Each one sets a sticky error bit, and writing 1 to that bit clears it.

Each FIFO tracks its occupancy with a three-state machine:
- States: `LV_EMPTY`, `LV_PART` and `LV_FULL`.
- Transition `fill_start` (`LV_EMPTY` to `LV_PART`): an accepted push.
- Transition `fill_top` (`LV_PART` to `LV_FULL`): a push without a pop at count 7.
- Transition `drain_last` (`LV_PART` to `LV_EMPTY`): a pop without a push at count 1.
- Transition `drain_start` (`LV_FULL` to `LV_PART`): a pop without a push.
- Every other case keeps the current state.

Top module: `serport_fifo_bank`

## Requirements
- R1: Each FIFO stores up to 8 words. Words leave in the order they arrived, and the head output shows the oldest stored word.
- R2: Each word count is a value from 0 to 8. It changes at the clock edge of each accepted push or pop. A push and a pop in the same cycle on a non-empty FIFO leave the count unchanged.
- R3: A configuration write loads the watermarks from these bits: transmit 0 from bits 3:0, receive from bits 7:4, transmit 1 from bits 19:16. A transmit code of 0 is stored as 1, and a transmit code of 9 to 15 is stored as 8. A receive code of 0 is stored as 1. After reset both transmit watermarks are 1 and the receive watermark is 4.
- R4: Transmit flag i (tx_flag bit i) is high when 8 minus the transmit FIFO i count is at least its watermark. The flag is registered: it reflects the count and watermark held in the previous cycle.
- R5: With transmit watermark 8, the flag is high only at count 0. With watermark 1, the flag is high at every count from 0 to 7.
- R6: Each transmit FIFO, its watermark and its flag are independent of the other transmit FIFO.
- R7: The receive flag is high when the receive count is at least the receive watermark. The flag is registered in the same way as R4, and a watermark above 8 never raises it.
- R8: The status word holds these fields: bits 3:0 transmit watermark 0, bits 7:4 receive watermark, bits 11:8 transmit FIFO 0 count, bits 15:12 receive count, bits 19:16 transmit watermark 1. Output tx1_count carries the transmit FIFO 1 count.
- R9: A push into a full FIFO, with no pop in the same cycle, is ignored and sets that FIFO's overrun bit. A pop from an empty FIFO is ignored and sets its underrun bit. The err bits are assigned as follows: bit 0 tx0 overrun, bit 1 tx0 underrun, bit 2 tx1 overrun, bit 3 tx1 underrun, bit 4 rx overrun, bit 5 rx underrun.
- R10: An error bit stays set until a 1 is written to the same bit of err_clr. If a new error and a clear arrive in the same cycle, the bit stays set.
- R11: After reset every count is 0, both transmit flags are 1, the receive flag is 0, the error bits are 0, and the status word is 20'h10041.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Watermark write strobe |
| cfg_wdata | input | 20 | Watermark codes (fields per R3) |
| err_clr | input | 6 | Write-1-to-clear for the error bits |
| tx_push | input | 2 | Host push strobe, one bit per transmit FIFO |
| tx_push_data | input | 2*DW | Push data, FIFO i in bits [i*DW +: DW] |
| tx_pop | input | 2 | Shifter pop strobe per transmit FIFO |
| tx_head | output | 2*DW | Oldest word of each transmit FIFO |
| rx_push | input | 1 | Shifter push strobe for the receive FIFO |
| rx_push_data | input | DW | Receive push data |
| rx_pop | input | 1 | Host pop strobe for the receive FIFO |
| rx_head | output | DW | Oldest word of the receive FIFO |
| status | output | 20 | Watermarks and counts (R8) |
| tx1_count | output | 4 | Transmit FIFO 1 word count |
| tx_flag | output | 2 | Transmit free-space flags |
| rx_flag | output | 1 | Receive level flag |
| err | output | 6 | Sticky overrun and underrun bits |

## Verification
Counts, head words and error bits take their new values at the rising edge that accepts a request, so they are due one cycle after the request is applied. The level flags are computed from the count and watermark held before that edge, so a flag follows its count one cycle later. A watermark write affects its flag at the edge after the write. The bench drives every request at a falling edge and waits for the next rising edge. It then compares all outputs at the following falling edge, against a model whose expected flags are taken from the model's state before the step.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    localparam int FLD_W = 4;
    localparam int NTX   = 2;
    localparam int STAT_W = 5 * FLD_W;

    typedef enum logic [1:0] {
        LV_EMPTY = 2'd0,
        LV_PART  = 2'd1,
        LV_FULL  = 2'd2
    } lvl_e;

    function automatic logic [FLD_W-1:0] fix_tx_wm(input logic [FLD_W-1:0] code, input int depth);
        if (code == '0) return FLD_W'(1);
        if (int'(code) > depth) return FLD_W'(depth);
        return code;
    endfunction

    function automatic logic [FLD_W-1:0] fix_rx_wm(input logic [FLD_W-1:0] code);
        if (code == '0) return FLD_W'(1);
        return code;
    endfunction

endpackage

// File: rtl/sfb_fifo_core.sv
module sfb_fifo_core
    import sfb_pkg::*;
#(
    parameter  int DW    = 16,
    parameter  int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    input  logic [1:0]       err_clr,
    output logic [DW-1:0]    head,
    output logic [CNT_W-1:0] count,
    output logic [1:0]       err
);

    lvl_e             state_q, state_d;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count_q;
    logic [1:0]       err_q;
    logic [DW-1:0]    mem [DEPTH];
    logic             pop_ok, push_ok;

    assign pop_ok  = pop && (state_q != LV_EMPTY);
    assign push_ok = push && ((state_q != LV_FULL) || pop_ok);

    // occupancy state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LV_EMPTY;
        else        state_q <= state_d;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LV_EMPTY: if (push_ok) state_d = LV_PART;                       // fill_start
            LV_PART: begin
                if (push_ok && !pop_ok && count_q == CNT_W'(DEPTH - 1))
                    state_d = LV_FULL;                                       // fill_top
                else if (pop_ok && !push_ok && count_q == CNT_W'(1))
                    state_d = LV_EMPTY;                                      // drain_last
            end
            LV_FULL:  if (pop_ok && !push_ok) state_d = LV_PART;            // drain_start
            default:  state_d = LV_EMPTY;
        endcase
    end

    // outputs: pointers, count, sticky errors
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
            err_q   <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            if (pop_ok)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            if (push_ok && !pop_ok)      count_q <= count_q + CNT_W'(1);
            else if (pop_ok && !push_ok) count_q <= count_q - CNT_W'(1);
            err_q <= (err_q & ~err_clr) | {pop && !pop_ok, push && !push_ok};
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    assign head  = mem[rd_ptr];
    assign count = count_q;
    assign err   = err_q;

    assert_count_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    assert_full_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LV_FULL) |-> (count_q == CNT_W'(DEPTH)));

    assert_pushpop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && count_q != '0) |=> $stable(count_q));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_W'(DEPTH) && push && !pop) |=> (count_q == CNT_W'(DEPTH) && err_q[0]));

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && pop && !push) |=> (count_q == '0 && err_q[1]));

endmodule

// File: rtl/sfb_wm_regs.sv
module sfb_wm_regs
    import sfb_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int RX_RST = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_wr,
    input  logic [STAT_W-1:0]           cfg_wdata,
    output logic [NTX-1:0][FLD_W-1:0]   tx_wm,
    output logic [FLD_W-1:0]            rx_wm
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_wm[0] <= FLD_W'(1);
            tx_wm[1] <= FLD_W'(1);
            rx_wm    <= FLD_W'(RX_RST);
        end else if (cfg_wr) begin
            tx_wm[0] <= fix_tx_wm(cfg_wdata[3:0], DEPTH);
            rx_wm    <= fix_rx_wm(cfg_wdata[7:4]);
            tx_wm[1] <= fix_tx_wm(cfg_wdata[19:16], DEPTH);
        end
    end

    assert_txwm_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wm[0] != '0) && (tx_wm[1] != '0) &&
        (int'(tx_wm[0]) <= DEPTH) && (int'(tx_wm[1]) <= DEPTH));

    assert_rxwm_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (rx_wm != '0));

endmodule

// File: rtl/sfb_wm_flag.sv
module sfb_wm_flag
    import sfb_pkg::*;
#(
    parameter  bit IS_TX = 1'b1,
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int SW    = FLD_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [FLD_W-1:0] wm,
    output logic             flag
);

    localparam logic RST_VAL = IS_TX;
    logic [SW-1:0] cnt_x, wm_x;
    logic          hit;

    assign cnt_x = SW'(count);
    assign wm_x  = SW'(wm);

    generate
        if (IS_TX) begin : g_free
            assign hit = (SW'(DEPTH) - cnt_x) >= wm_x;
        end else begin : g_fill
            assign hit = cnt_x >= wm_x;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag <= RST_VAL;
        else        flag <= hit;
    end

    generate
        if (IS_TX) begin : g_chk_tx
            assert_tx_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(count) == '0) |-> flag);
            assert_tx_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(count) == CNT_W'(DEPTH)) |-> !flag);
        end else begin : g_chk_rx
            assert_rx_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(count) == '0) |-> !flag);
        end
    endgenerate

endmodule

// File: rtl/serport_fifo_bank.sv
module serport_fifo_bank
    import sfb_pkg::*;
#(
    parameter int DW     = 16,
    parameter int DEPTH  = 8,
    parameter int RX_RST = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [19:0]          cfg_wdata,
    input  logic [5:0]           err_clr,
    input  logic [1:0]           tx_push,
    input  logic [2*DW-1:0]      tx_push_data,
    input  logic [1:0]           tx_pop,
    output logic [2*DW-1:0]      tx_head,
    input  logic                 rx_push,
    input  logic [DW-1:0]        rx_push_data,
    input  logic                 rx_pop,
    output logic [DW-1:0]        rx_head,
    output logic [19:0]          status,
    output logic [3:0]           tx1_count,
    output logic [1:0]           tx_flag,
    output logic                 rx_flag,
    output logic [5:0]           err
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [NTX-1:0][FLD_W-1:0] tx_wm;
    logic [FLD_W-1:0]          rx_wm;
    logic [NTX-1:0][CNT_W-1:0] tx_cnt;
    logic [CNT_W-1:0]          rx_cnt;
    logic [NTX-1:0][1:0]       tx_err;
    logic [1:0]                rx_err;

    sfb_wm_regs #(.DEPTH(DEPTH), .RX_RST(RX_RST)) u_wm (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .tx_wm(tx_wm), .rx_wm(rx_wm)
    );

    generate
        for (genvar i = 0; i < NTX; i++) begin : g_tx
            sfb_fifo_core #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
                .clk(clk), .rst_n(rst_n),
                .push(tx_push[i]), .push_data(tx_push_data[i*DW +: DW]),
                .pop(tx_pop[i]), .err_clr(err_clr[2*i +: 2]),
                .head(tx_head[i*DW +: DW]), .count(tx_cnt[i]), .err(tx_err[i])
            );
            sfb_wm_flag #(.IS_TX(1'b1), .DEPTH(DEPTH)) u_flag (
                .clk(clk), .rst_n(rst_n), .count(tx_cnt[i]), .wm(tx_wm[i]),
                .flag(tx_flag[i])
            );
        end
    endgenerate

    sfb_fifo_core #(.DW(DW), .DEPTH(DEPTH)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_push_data),
        .pop(rx_pop), .err_clr(err_clr[5:4]),
        .head(rx_head), .count(rx_cnt), .err(rx_err)
    );

    sfb_wm_flag #(.IS_TX(1'b0), .DEPTH(DEPTH)) u_rx_flag (
        .clk(clk), .rst_n(rst_n), .count(rx_cnt), .wm(rx_wm), .flag(rx_flag)
    );

    assign status    = {tx_wm[1], FLD_W'(rx_cnt), FLD_W'(tx_cnt[0]), rx_wm, tx_wm[0]};
    assign tx1_count = FLD_W'(tx_cnt[1]);
    assign err       = {rx_err, tx_err[1], tx_err[0]};

endmodule

// File: tb/sim_serport_fifo_bank.sv
`timescale 1ns/1ps
module sim_serport_fifo_bank;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [19:0]   cfg_wdata = '0;
    logic [5:0]    err_clr = '0;
    logic [1:0]    tx_push = '0, tx_pop = '0;
    logic [2*DW-1:0] tx_push_data = '0;
    logic [2*DW-1:0] tx_head;
    logic          rx_push = 1'b0, rx_pop = 1'b0;
    logic [DW-1:0] rx_push_data = '0;
    logic [DW-1:0] rx_head;
    logic [19:0]   status;
    logic [3:0]    tx1_count;
    logic [1:0]    tx_flag;
    logic          rx_flag;
    logic [5:0]    err;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [DW-1:0] seq = 16'h1000;

    // model state
    int cnt[3];
    int wm_t[2];
    int wm_r;
    logic [5:0] m_err;
    logic [DW-1:0] q0[$], q1[$], qr[$];

    always #2.5 clk = ~clk;

    serport_fifo_bank #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .err_clr(err_clr), .tx_push(tx_push), .tx_push_data(tx_push_data),
        .tx_pop(tx_pop), .tx_head(tx_head), .rx_push(rx_push),
        .rx_push_data(rx_push_data), .rx_pop(rx_pop), .rx_head(rx_head),
        .status(status), .tx1_count(tx1_count), .tx_flag(tx_flag),
        .rx_flag(rx_flag), .err(err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // scoreboard for one FIFO: i = 0,1 transmit, 2 receive
    task automatic sb_fifo(input int i, input logic push, input logic pop,
                           input logic [DW-1:0] d, input logic [DW-1:0] hd);
        logic [DW-1:0] expd;
        bit pok, wok;
        pok = pop && (cnt[i] > 0);
        wok = push && ((cnt[i] < 8) || pok);
        if (pok) begin
            case (i)
                0: expd = q0.pop_front();
                1: expd = q1.pop_front();
                default: expd = qr.pop_front();
            endcase
            chk($sformatf("R1 head fifo %0d", i), 32'(hd), 32'(expd));
        end
        if (wok) begin
            case (i)
                0: q0.push_back(d);
                1: q1.push_back(d);
                default: qr.push_back(d);
            endcase
        end
        cnt[i] = cnt[i] + int'(wok) - int'(pok);
        if (push && !wok) m_err[2*i] = 1'b1;
        if (pop && !pok)  m_err[2*i+1] = 1'b1;
    endtask

    function automatic int tx_code(input int c);
        if (c == 0) return 1;
        if (c > 8) return 8;
        return c;
    endfunction

    task automatic step(input logic [1:0] tp, input logic [1:0] tq, input logic rp,
                        input logic rq, input logic wr, input logic [19:0] wd,
                        input logic [5:0] clr);
        logic [1:0] ef_t;
        logic ef_r;
        logic [DW-1:0] d0, d1, dr;
        d0 = seq; d1 = seq + 16'h0100; dr = seq + 16'h0200; seq = seq + 16'd1;
        tx_push = tp; tx_pop = tq; rx_push = rp; rx_pop = rq;
        tx_push_data = {d1, d0}; rx_push_data = dr;
        cfg_wr = wr; cfg_wdata = wd; err_clr = clr;
        #0.1;
        for (int i = 0; i < 2; i++) ef_t[i] = ((8 - cnt[i]) >= wm_t[i]);
        ef_r = (cnt[2] >= wm_r);
        m_err = m_err & ~clr;
        sb_fifo(0, tp[0], tq[0], d0, tx_head[DW-1:0]);
        sb_fifo(1, tp[1], tq[1], d1, tx_head[2*DW-1:DW]);
        sb_fifo(2, rp, rq, dr, rx_head);
        if (wr) begin
            wm_t[0] = tx_code(int'(wd[3:0]));
            wm_t[1] = tx_code(int'(wd[19:16]));
            wm_r    = (wd[7:4] == 4'd0) ? 1 : int'(wd[7:4]);
        end
        @(posedge clk);
        @(negedge clk);
        chk("R2 tx0 count", 32'(status[11:8]), 32'(cnt[0]));
        chk("R2 tx1 count", 32'(tx1_count), 32'(cnt[1]));
        chk("R2 rx count", 32'(status[15:12]), 32'(cnt[2]));
        chk("R3 watermarks", {12'd0, status[19:16], 8'd0, status[7:4], status[3:0]},
            {12'd0, 4'(wm_t[1]), 8'd0, 4'(wm_r), 4'(wm_t[0])});
        chk("R8 status word", 32'(status),
            32'({4'(wm_t[1]), 4'(cnt[2]), 4'(cnt[0]), 4'(wm_r), 4'(wm_t[0])}));
        chk("R4 tx flags", 32'(tx_flag), 32'(ef_t));
        chk("R7 rx flag", 32'(rx_flag), 32'(ef_r));
        chk("R9 R10 err bits", 32'(err), 32'(m_err));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 20'h0, 6'h0);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) cnt[i] = 0;
        wm_t[0] = 1; wm_t[1] = 1; wm_r = 4; m_err = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 reset status", 32'(status), 32'h10041);
        chk("R11 reset tx flags", 32'(tx_flag), 32'h3);
        chk("R11 reset rx flag", 32'(rx_flag), 32'h0);
        chk("R11 reset err", 32'(err), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // fill tx0 to full, watermark 1
        for (int k = 0; k < 8; k++) step(2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 20'h0, 6'h0);
        idle(1);
        chk("R5 tx0 flag low when full at wm 1", 32'(tx_flag[0]), 32'h0);
        chk("R6 tx1 flag unaffected by tx0", 32'(tx_flag[1]), 32'h1);
        // overrun on full
        step(2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 20'h0, 6'h0);
        chk("R9 overrun keeps count 8", 32'(status[11:8]), 32'd8);
        chk("R9 tx0 overrun bit", 32'(err[0]), 32'h1);
        // push+pop on full: no overrun, count stays
        step(2'b01, 2'b01, 1'b0, 1'b0, 1'b0, 20'h0, 6'h1);
        chk("R2 push and pop at full", 32'(status[11:8]), 32'd8);
        chk("R10 overrun cleared", 32'(err[0]), 32'h0);
        // drain tx0
        for (int k = 0; k < 8; k++) step(2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 20'h0, 6'h0);
        // underrun, then clear in same cycle as a new underrun (set wins)
        step(2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 20'h0, 6'h0);
        step(2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 20'h0, 6'h2);
        chk("R10 set wins over clear", 32'(err[1]), 32'h1);
        step(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 20'h0, 6'h2);
        chk("R10 underrun cleared", 32'(err[1]), 32'h0);

        // reserved / out-of-range codes
        step(2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 20'h90000, 6'h0);
        chk("R3 sanitized codes", 32'(status), 32'h80011);
        // tx1 watermark 8: flag only at empty
        step(2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 20'h0, 6'h0);
        idle(1);
        chk("R5 tx1 flag low with one word at wm 8", 32'(tx_flag[1]), 32'h0);
        step(2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 20'h0, 6'h0);
        step(2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 20'h0, 6'h0);
        step(2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 20'h0, 6'h0);
        idle(1);
        chk("R5 tx1 flag high at empty", 32'(tx_flag[1]), 32'h1);

        // tx0 wm 5, tx1 wm 2, rx wm 3
        step(2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 20'h20035, 6'h0);
        for (int k = 0; k < 5; k++) step(2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 20'h0, 6'h0);
        for (int k = 0; k < 4; k++) step(2'b11, 2'b11, 1'b0, 1'b0, 1'b0, 20'h0, 6'h0);
        chk("R2 simultaneous push pop count", 32'(status[11:8]), 32'd5);
        for (int k = 0; k < 5; k++) step(2'b00, 2'b11, 1'b0, 1'b0, 1'b0, 20'h0, 6'h0);

        // receive: wm 3
        for (int k = 0; k < 4; k++) step(2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 20'h0, 6'h0);
        chk("R7 rx flag at fill >= 3", 32'(rx_flag), 32'h1);
        for (int k = 0; k < 4; k++) step(2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 20'h0, 6'h0);
        // rx wm 12 never fires
        step(2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 20'h100C1, 6'h0);
        for (int k = 0; k < 9; k++) step(2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 20'h0, 6'h0);
        idle(1);
        chk("R7 rx flag never at wm 12", 32'(rx_flag), 32'h0);
        chk("R9 rx overrun bit", 32'(err[4]), 32'h1);
        for (int k = 0; k < 9; k++) step(2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 20'h0, 6'h0);
        chk("R9 rx underrun bit", 32'(err[5]), 32'h1);
        step(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 20'h0, 6'h3F);
        idle(2);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule